// File: doc/BRIEF.md
# Stream Line Prefetcher

This block sits on the miss side of a last-level cache, between the demand miss stream and the memory request port. It watches each demand miss and adds line-fill requests of its own, so that regular streaming code finds its data already on the way. It has two independently enabled mechanisms. The first pairs every miss with the other 64-byte line of its 128-byte aligned block. The second keeps a small table of recently missed 4 KB pages. When one page sees two misses on consecutive ascending lines, it sweeps the rest of that page.

Each candidate line is put to a presence query (`probe_valid`, `probe_addr`). The environment answers in the same cycle with `probe_hit`, which means the line is already cached or already requested. Lines that hit are dropped. The others enter an internal queue that drains through a valid/ready output. Misses are registered on entry. A pair candidate goes before any sweep line. Several sweeps can be live at once, and the one in the lowest table entry is served first.

Top module: `stream_prefetcher`

## Requirements
- R1: With `cfg_pair_en`=1, a miss at byte address A yields a request for A with bit 6 inverted (the same bits above bit 6, bits 5:0 zero), unless the probe for that line reports a hit.
- R2: With `cfg_pair_en`=0, no pair request is made for any miss.
- R3: With `cfg_page_en`=1, take a miss at line index L (bits 11:6) of a page (bits 31:12) whose tracked last line was L-1. It starts a sweep of that page in this order: L+1 up to 63, then 0 up to L-2. That is 62 candidates, and each is probed once.
- R4: These start no sweep: a stride other than +1, a descending step, a repeated line, a step from line 63 of one page to line 0 of the next, or any miss while `cfg_page_en`=0.
- R5: Every candidate appears on `probe_addr` with `probe_valid`=1 for the cycle in which it is decided. With `probe_hit`=1 it is dropped; otherwise it is queued for output.
- R6: Once a page has been swept, a further consecutive pair of misses on that page starts nothing while the page stays in the table.
- R7: The table holds 4 pages and replaces the least recently missed page that is not sweeping. An evicted page loses its last-line history, so its next consecutive miss does not trigger.
- R8: A trigger on another page neither aborts nor repeats a sweep in progress. Two overlapping sweeps together deliver every missing line of both pages exactly once.
- R9: Outputs leave in decision order. While `pf_valid`=1 and `pf_ready`=0, `pf_valid` stays 1 and `pf_addr` holds.
- R10: After reset, `pf_valid` and `probe_valid` are 0 and the page table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pair_en | input | 1 | Enables the 128-byte pair request |
| cfg_page_en | input | 1 | Enables the page sweep trigger |
| miss_valid | input | 1 | Demand miss present this cycle |
| miss_addr | input | 32 | Demand miss byte address |
| probe_valid | output | 1 | A candidate line is being decided this cycle |
| probe_addr | output | 32 | Line-aligned address of the candidate |
| probe_hit | input | 1 | Candidate is already cached or requested |
| pf_valid | output | 1 | Prefetch request available |
| pf_ready | input | 1 | Memory port accepts the request |
| pf_addr | output | 32 | Line-aligned prefetch address |

## Verification
A wrong tracker page or last-line field shows up at the ports as a sweep that is missing or unwanted. This can be seen within three cycles of the triggering miss, because the first candidate then appears or fails to appear on `probe_addr`. A corrupted sweep position or count shows as a gap, a repeat, or a wrong wrap point in the address sequence. The sequence is compared line by line against an arithmetic model in the bench. Errors in the age ordering stay hidden until a fifth page is missed. After that, the wrong page loses its history, and the next consecutive pair on that page either sweeps when it should not or stays silent.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // which source supplies the candidate under probe this cycle
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_PAIR  = 2'd1,
    SRC_SWEEP = 2'd2
  } cand_src_e;
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pf_tracker.sv
module pf_tracker #(
  parameter int PAGE_W  = 20,
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_v,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              trig_en,
  input  logic              take,
  output logic              sw_any,
  output logic [PAGE_W-1:0] sw_page,
  output logic [IDX_W-1:0]  sw_idx
);
  localparam int SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int LINES     = 1 << IDX_W;
  localparam int SWEEP_LEN = LINES - 2;

  logic              trk_v     [ENTRIES];
  logic [PAGE_W-1:0] trk_page  [ENTRIES];
  logic [IDX_W-1:0]  trk_last  [ENTRIES];
  logic              trk_swept [ENTRIES];
  logic [SEL_W-1:0]  trk_age   [ENTRIES];
  logic              sw_act    [ENTRIES];
  logic [IDX_W-1:0]  sw_pos    [ENTRIES];
  logic [IDX_W-1:0]  sw_left   [ENTRIES];

  logic             hit_any, free_any, vic_any, new_any, touch_v, trig;
  logic [SEL_W-1:0] hit_sel, free_sel, vic_sel, new_sel, touch_sel, sw_sel, vic_age;

  // page lookup, free slot and oldest idle victim
  always_comb begin
    hit_any  = 1'b0; hit_sel  = '0;
    free_any = 1'b0; free_sel = '0;
    vic_any  = 1'b0; vic_sel  = '0; vic_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (trk_v[i] && (trk_page[i] == upd_page) && !hit_any) begin
        hit_any = 1'b1;
        hit_sel = SEL_W'(i);
      end
      if (!trk_v[i] && !free_any) begin
        free_any = 1'b1;
        free_sel = SEL_W'(i);
      end
      if (trk_v[i] && !sw_act[i] && (!vic_any || (trk_age[i] > vic_age))) begin
        vic_any = 1'b1;
        vic_sel = SEL_W'(i);
        vic_age = trk_age[i];
      end
    end
    new_any   = free_any || vic_any;
    new_sel   = free_any ? free_sel : vic_sel;
    touch_v   = upd_v && (hit_any || new_any);
    touch_sel = hit_any ? hit_sel : new_sel;
    trig      = upd_v && hit_any && trig_en && !trk_swept[hit_sel] &&
                (trk_last[hit_sel] != '1) &&
                (upd_idx == IDX_W'(trk_last[hit_sel] + IDX_W'(1)));
  end

  // lowest-numbered live sweep owns the candidate slot
  always_comb begin
    sw_any = 1'b0;
    sw_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (sw_act[i]) begin
        sw_any = 1'b1;
        sw_sel = SEL_W'(i);
      end
    end
    sw_page = trk_page[sw_sel];
    sw_idx  = sw_pos[sw_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        trk_v[i]     <= 1'b0;
        trk_page[i]  <= '0;
        trk_last[i]  <= '0;
        trk_swept[i] <= 1'b0;
        trk_age[i]   <= SEL_W'(i);
        sw_act[i]    <= 1'b0;
        sw_pos[i]    <= '0;
        sw_left[i]   <= '0;
      end
    end else begin
      if (take && sw_any) begin
        sw_pos[sw_sel]  <= sw_pos[sw_sel] + IDX_W'(1);
        sw_left[sw_sel] <= sw_left[sw_sel] - IDX_W'(1);
        if (sw_left[sw_sel] == IDX_W'(1)) sw_act[sw_sel] <= 1'b0;
      end
      if (upd_v && hit_any) begin
        trk_last[hit_sel] <= upd_idx;
        if (trig) begin
          trk_swept[hit_sel] <= 1'b1;
          sw_act[hit_sel]    <= 1'b1;
          sw_pos[hit_sel]    <= upd_idx + IDX_W'(1);
          sw_left[hit_sel]   <= IDX_W'(SWEEP_LEN);
        end
      end else if (upd_v && new_any) begin
        trk_v[new_sel]     <= 1'b1;
        trk_page[new_sel]  <= upd_page;
        trk_last[new_sel]  <= upd_idx;
        trk_swept[new_sel] <= 1'b0;
      end
      if (touch_v) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (SEL_W'(i) == touch_sel)          trk_age[i] <= '0;
          else if (trk_age[i] < trk_age[touch_sel]) trk_age[i] <= trk_age[i] + SEL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12,
  parameter int TRACK_N   = 4,
  parameter int QDEPTH    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pair_en,
  input  logic              cfg_page_en,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_hit,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  import pf_pkg::*;

  localparam int IDX_W  = PAGE_BITS - LINE_BITS;
  localparam int PAGE_W = ADDR_W - PAGE_BITS;
  localparam int LNUM_W = ADDR_W - LINE_BITS;

  logic              m_v;
  logic [PAGE_W-1:0] m_page;
  logic [IDX_W-1:0]  m_idx;
  logic              pair_v;
  logic [PAGE_W-1:0] pair_page;
  logic [IDX_W-1:0]  pair_idx;
  logic              sw_any, sw_take, pair_take, push, q_full, q_empty;
  logic [PAGE_W-1:0] sw_page;
  logic [IDX_W-1:0]  sw_idx;
  logic [LNUM_W-1:0] cand_line, q_line;
  cand_src_e         src;
  logic              unused_low;

  assign unused_low = ^miss_addr[LINE_BITS-1:0];

  // registered miss capture
  always_ff @(posedge clk) begin
    if (rst) begin
      m_v    <= 1'b0;
      m_page <= '0;
      m_idx  <= '0;
    end else begin
      m_v    <= miss_valid;
      m_page <= miss_addr[ADDR_W-1:PAGE_BITS];
      m_idx  <= miss_addr[PAGE_BITS-1:LINE_BITS];
    end
  end

  // pending partner line of the aligned pair; a newer miss replaces it
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_v    <= 1'b0;
      pair_page <= '0;
      pair_idx  <= '0;
    end else if (m_v && cfg_pair_en) begin
      pair_v    <= 1'b1;
      pair_page <= m_page;
      pair_idx  <= {m_idx[IDX_W-1:1], ~m_idx[0]};
    end else if (pair_take) begin
      pair_v <= 1'b0;
    end
  end

  pf_tracker #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .ENTRIES(TRACK_N)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .upd_v    (m_v),
    .upd_page (m_page),
    .upd_idx  (m_idx),
    .trig_en  (cfg_page_en),
    .take     (sw_take),
    .sw_any   (sw_any),
    .sw_page  (sw_page),
    .sw_idx   (sw_idx)
  );

  // candidate arbitration: pair first, then sweep
  always_comb begin
    if (pair_v)      src = SRC_PAIR;
    else if (sw_any) src = SRC_SWEEP;
    else             src = SRC_NONE;
    cand_line = (src == SRC_PAIR) ? {pair_page, pair_idx} : {sw_page, sw_idx};
  end

  assign probe_valid = (src != SRC_NONE) && !q_full;
  assign probe_addr  = {cand_line, {LINE_BITS{1'b0}}};
  assign push        = probe_valid && !probe_hit;
  assign pair_take   = probe_valid && (src == SRC_PAIR);
  assign sw_take     = probe_valid && (src == SRC_SWEEP);

  pf_fifo #(.W(LNUM_W), .DEPTH(QDEPTH)) u_q (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (cand_line),
    .pop   (pf_valid && pf_ready),
    .dout  (q_line),
    .empty (q_empty),
    .full  (q_full)
  );

  assign pf_valid = !q_empty;
  assign pf_addr  = {q_line, {LINE_BITS{1'b0}}};
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              probe_valid,
  input logic              probe_hit
);
  // R9
  pf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  // R5
  pf_push_chk: assert property (@(posedge clk) disable iff (rst)
    probe_valid && !probe_hit |=> pf_valid);

  // R5
  pf_skip_chk: assert property (@(posedge clk) disable iff (rst)
    probe_valid && probe_hit && !pf_valid |=> !pf_valid);

  // R10
  pf_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pf_valid && !probe_valid);
endmodule

bind stream_prefetcher pf_checker #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_chk (.*);

// File: tb/tb_stream_prefetcher.sv
module tb_stream_prefetcher;
  localparam int CLK_PERIOD = 10;
  localparam int NPAGES     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_pair_en = 1'b0, cfg_page_en = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        probe_valid, probe_hit, pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] probe_addr, pf_addr;
  logic        evict_v = 1'b0;
  int          evict_pg = 0;
  logic        rdy_rand = 1'b0;
  logic        order_mode = 1'b1;
  string       cur_req = "R10";

  bit   present [NPAGES*64];
  bit   mdl     [NPAGES*64];
  bit   seen    [NPAGES*64];
  logic [31:0] exp_q [1024];
  int   exp_wr = 0, exp_rd = 0;
  int   checks = 0, fails = 0, mon_checks = 0, mon_fails = 0, mon_outs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prefetcher dut (
    .clk(clk), .rst(rst), .cfg_pair_en(cfg_pair_en), .cfg_page_en(cfg_page_en),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  // environment: a line is present once demanded or once queued
  assign probe_hit = probe_valid && present[probe_addr[14:6]];

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAGES*64; k++) present[k] <= 1'b0;
    end else begin
      if (miss_valid) present[miss_addr[14:6]] <= 1'b1;
      if (probe_valid && !probe_hit) present[probe_addr[14:6]] <= 1'b1;
      if (evict_v) for (int k = 0; k < 64; k++) present[evict_pg*64 + k] <= 1'b0;
    end
  end

  initial begin : ready_drv
    logic [15:0] lf;
    lf = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pf_ready = rdy_rand ? lf[0] : 1'b1;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAGES*64; k++) seen[k] = 1'b0;
    end else if (pf_valid && pf_ready) begin
      mon_outs++;
      mon_checks++;
      if (order_mode) begin
        if (exp_rd >= exp_wr) begin
          mon_fails++;
          $display("FAIL %s: unexpected request actual %h expected none", cur_req, pf_addr);
        end else begin
          if (pf_addr !== exp_q[exp_rd]) begin
            mon_fails++;
            $display("FAIL %s: request actual %h expected %h", cur_req, pf_addr, exp_q[exp_rd]);
          end
          exp_rd++;
        end
      end else begin
        if (seen[pf_addr[14:6]]) begin
          mon_fails++;
          $display("FAIL %s: repeated request actual %h expected a new line", cur_req, pf_addr);
        end
        seen[pf_addr[14:6]] = 1'b1;
      end
    end
  end

  function automatic logic [31:0] mk(int pg, int ix);
    return 32'(pg*4096 + ix*64);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic exp_push(int pg, int ix);
    exp_q[exp_wr] = mk(pg, ix);
    exp_wr++;
    mdl[pg*64 + ix] = 1'b1;
  endtask

  task automatic exp_sweep(int pg, int l);
    for (int k = 1; k <= 62; k++) begin
      int ix = (l + k) % 64;
      if (!mdl[pg*64 + ix]) exp_push(pg, ix);
    end
  endtask

  task automatic wait_idle();
    int quiet = 0;
    repeat (4) @(negedge clk);
    while (quiet < 4) begin
      @(negedge clk);
      if (!probe_valid && !pf_valid) quiet++;
      else quiet = 0;
    end
  endtask

  // demand miss, plus the pair expectation it implies (R1)
  task automatic hit(int pg, int ix);
    @(posedge clk); #1;
    miss_valid = 1'b1;
    miss_addr  = mk(pg, ix) + 32'(ix % 7);
    @(posedge clk); #1;
    miss_valid = 1'b0;
    mdl[pg*64 + ix] = 1'b1;
    if (cfg_pair_en && !mdl[pg*64 + (ix ^ 1)]) exp_push(pg, ix ^ 1);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    for (int k = 0; k < NPAGES*64; k++) mdl[k] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic drained(string req);
    chk(exp_rd == exp_wr, req, exp_rd, exp_wr);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin : main
    int base;
    logic [31:0] rs;
    rs = 32'h1234_5678;

    // R10 reset state
    do_reset();
    @(negedge clk);
    chk(!pf_valid, "R10 pf_valid", int'(pf_valid), 0);
    chk(!probe_valid, "R10 probe_valid", int'(probe_valid), 0);

    // R1 random stream with pair fetch, page sweep off (R4)
    cur_req = "R1"; cfg_pair_en = 1'b1; cfg_page_en = 1'b0;
    for (int n = 0; n < 20; n++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      hit(int'(rs % NPAGES), int'((rs >> 3) % 64));
      wait_idle();
    end
    drained("R1");

    // R2 pair fetch off, R4 consecutive lines while page sweep off
    cur_req = "R2"; cfg_pair_en = 1'b0;
    base = mon_outs;
    hit(3, 4); wait_idle();
    hit(3, 5); wait_idle();
    chk(mon_outs == base, "R2", mon_outs - base, 0);
    drained("R2");

    // R3 R5 R9 sequential stream with pre-present lines and backpressure
    do_reset();
    cur_req = "R3"; cfg_page_en = 1'b1; cfg_pair_en = 1'b0; rdy_rand = 1'b1;
    hit(2, 10); wait_idle();
    hit(2, 0);  wait_idle();
    cfg_pair_en = 1'b1;
    hit(2, 5); wait_idle();
    hit(2, 6); exp_sweep(2, 6); wait_idle();
    drained("R3 R5 R9 sequential");
    rdy_rand = 1'b0;

    // R3 wrap order from line 40
    do_reset();
    cfg_pair_en = 1'b0;
    hit(0, 39); wait_idle();
    hit(0, 40); exp_sweep(0, 40); wait_idle();
    drained("R3 wrap");

    // R4 stride-2, descending, repeat, page crossing, enable off
    cur_req = "R4"; base = mon_outs;
    for (int ix = 0; ix <= 20; ix += 2) begin hit(3, ix); wait_idle(); end
    chk(mon_outs == base, "R4 stride2", mon_outs - base, 0);
    hit(4, 10); wait_idle(); hit(4, 9); wait_idle(); hit(4, 9); wait_idle();
    chk(mon_outs == base, "R4 descending/repeat", mon_outs - base, 0);
    cfg_page_en = 1'b0;
    hit(1, 30); wait_idle(); hit(1, 31); wait_idle();
    chk(mon_outs == base, "R4 enable off", mon_outs - base, 0);
    cfg_page_en = 1'b1; cur_req = "R3";
    hit(1, 32); exp_sweep(1, 32); wait_idle();
    drained("R3 after enable");
    cur_req = "R4"; base = mon_outs;
    hit(6, 63); wait_idle(); hit(7, 0); wait_idle();
    chk(mon_outs == base, "R4 page crossing", mon_outs - base, 0);

    // R3 top of page, then R6 retrigger after eviction
    do_reset();
    cur_req = "R3";
    hit(5, 62); wait_idle();
    hit(5, 63); exp_sweep(5, 63); wait_idle();
    drained("R3 top edge");
    @(posedge clk); #1 evict_v = 1'b1; evict_pg = 5;
    @(posedge clk); #1 evict_v = 1'b0;
    for (int k = 0; k < 64; k++) mdl[5*64 + k] = 1'b0;
    cur_req = "R6"; base = mon_outs;
    hit(5, 20); wait_idle(); hit(5, 21); wait_idle();
    chk(mon_outs == base, "R6", mon_outs - base, 0);

    // R7 replacement by age
    do_reset();
    cur_req = "R7";
    for (int pg = 1; pg <= 5; pg++) begin hit(pg, 10); wait_idle(); end
    hit(2, 11); exp_sweep(2, 11); wait_idle();
    drained("R7 survivor sweeps");
    base = mon_outs;
    hit(1, 11); wait_idle();
    chk(mon_outs == base, "R7 evicted page", mon_outs - base, 0);

    // R8 overlapping sweeps on two pages
    do_reset();
    cur_req = "R8";
    hit(6, 0); wait_idle();
    hit(7, 0); wait_idle();
    order_mode = 1'b0; base = mon_outs;
    hit(6, 1);
    repeat (8) @(posedge clk);
    hit(7, 1);
    wait_idle();
    chk(mon_outs - base == 124, "R8 count", mon_outs - base, 124);
    begin
      int cnt = 0;
      for (int k = 6*64; k < 8*64; k++) if (present[k]) cnt++;
      chk(cnt == 128, "R8 coverage", cnt, 128);
    end
    order_mode = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule